// File: doc/BRIEF.md
# Preemptive Priority Crossbar Arbiter

This block connects a set of masters to a set of slaves. Each master posts one request: a target slave, a priority and a number of data beats. A slave that is free and has requests waiting picks one of them. The highest priority wins, and among equal priorities the request that has waited longest wins. The winner then passes through a fixed arbitration overhead and a fixed slave access delay. After that it moves one data word per cycle to the slave, on a routed valid/data/source path.

A global limit caps how many slaves may be reserved at once. Requests beyond that limit wait even when their own slave is free. A transfer in progress yields to a strictly higher-priority request for the same slave. The preemption happens at a beat boundary: the current beat completes, the master is told it is suspended, and the request rejoins the queue with its remaining beat count. When it is served again it continues from the next unsent beat.

Each master runs a small state machine:
- `MS_IDLE`: the master has no request.
- `MS_WAIT`: the request is queued. This covers both fresh and suspended requests.
- `MS_ARB`: the arbitration overhead is being counted.
- `MS_LAT`: the grant is high and the access delay is being counted.
- `MS_XFER`: beats are moving.

The transitions are:
- accept: `MS_IDLE` to `MS_WAIT`, on a request.
- select: `MS_WAIT` to `MS_ARB`, when the slave's picker chooses the master and capacity remains.
- arb_done: `MS_ARB` to `MS_LAT`.
- lat_done: `MS_LAT` to `MS_XFER`.
- finish: `MS_XFER` to `MS_IDLE`, on the last beat.
- yield: `MS_XFER` to `MS_WAIT`, on preemption.

Top module: `xbar_arb`

## Requirements
- R1: While reset is asserted, every `m_grant`, `m_ready`, `m_susp` and `s_valid` bit is 0.
- R2: A request accepted on clock edge k, to a free slave with capacity available, sees `m_grant` rise after edge k+1+ARB_LAT. Its first `m_ready` comes ACC_LAT edges after the grant rises.
- R3: A transfer asserts `m_ready` for exactly `m_beats` cycles; a count of 0 is treated as 1. In each such cycle the target slave `s` (the index given on `m_sid`) shows `s_valid`=1, `s_data` equal to that master's `m_wdata`, and `s_mst` equal to the master index.
- R4: When a slave becomes free, the waiting request with the numerically largest `m_prio` is served first.
- R5: Among waiting requests of equal priority, the one accepted earlier is served first. Requests accepted in the same cycle are served lowest master index first.
- R6: At no time are more than MAX_ACT masters granted. A request to a free slave waits while MAX_ACT slaves are reserved.
- R7: If a request of strictly higher priority than the active transfer waits for the same slave, the beat in that cycle still completes (`m_ready`=1). In the next cycle the preempted master has `m_susp`=1, `m_ready`=0 and `m_grant`=0.
- R8: A waiting request of equal or lower priority never suspends an active transfer.
- R9: A suspended transfer resumes later with its remaining beats only: the total `m_ready` cycles equal the original `m_beats`, no beat is repeated, and `m_susp` is 0 once it is selected again.
- R10: `m_req` from a master whose request is queued, suspended or in progress has no effect.
- R11: At most one master is granted to any one slave at a time.
- R12: Reset in the middle of a transfer empties all queues and clears every grant. A request after reset sees the R2 latency again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_req | input | N_MST | Per-master request strobe, taken only when that master is idle |
| m_sid | input | N_MST x SID_W | Target slave index per master |
| m_prio | input | N_MST x PRIO_W | Request priority; a larger value is more urgent |
| m_beats | input | N_MST x BEAT_W | Number of data beats in the request |
| m_wdata | input | N_MST x DATA_W | Current data word of each master |
| m_grant | output | N_MST | The master owns its slave (access delay or transfer) |
| m_ready | output | N_MST | A beat of this master is taken this cycle |
| m_susp | output | N_MST | The master's transfer is suspended and waiting to resume |
| s_valid | output | N_SLV | A beat is presented to this slave |
| s_data | output | N_SLV x DATA_W | Beat data routed to this slave |
| s_mst | output | N_SLV x MID_W | Index of the master driving this slave |

## Verification
The first pattern is a lone request, which sets the exact grant and first-beat latencies and the beat count against the routed data. The next patterns stack several requests on one busy slave:
- mixed priorities show that priority order holds;
- equal priorities accepted in reverse index order show that arrival order, not index, breaks ties;
- a strictly higher late arrival against an equal-priority one separates real preemption from spurious suspension. Its beat totals show that the resumed transfer neither drops nor repeats a beat.

Two requests to different slaves under a limit of one show the capacity cap. A repeated request from a busy master, and a reset in the middle of a transfer, show that surplus strobes are ignored and that queues are flushed.

// File: rtl/xbar_arb_pkg.sv
package xbar_arb_pkg;
    typedef enum logic [2:0] {
        MS_IDLE,
        MS_WAIT,
        MS_ARB,
        MS_LAT,
        MS_XFER
    } mst_state_e;
endpackage

// File: rtl/xbar_arb_mst.sv
module xbar_arb_mst
    import xbar_arb_pkg::*;
#(
    parameter int SID_W   = 1,
    parameter int PRIO_W  = 2,
    parameter int BEAT_W  = 4,
    parameter int AGE_W   = 4,
    parameter int ARB_LAT = 2,
    parameter int ACC_LAT = 3,
    localparam int MAXL   = (ARB_LAT > ACC_LAT) ? ARB_LAT : ACC_LAT,
    localparam int CNT_W  = $clog2(MAXL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [SID_W-1:0]  sid_in,
    input  logic [PRIO_W-1:0] prio_in,
    input  logic [BEAT_W-1:0] beats_in,
    input  logic              start,
    input  logic              preempt,
    output mst_state_e        state,
    output logic [SID_W-1:0]  sid_q,
    output logic [PRIO_W-1:0] prio_q,
    output logic [AGE_W-1:0]  age_q,
    output logic              grant,
    output logic              ready,
    output logic              susp
);
    logic [BEAT_W-1:0] rem_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              susp_q;

    // state register with the per-request context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= MS_IDLE;
            sid_q  <= '0;
            prio_q <= '0;
            age_q  <= '0;
            rem_q  <= '0;
            cnt_q  <= '0;
            susp_q <= 1'b0;
        end else begin
            unique case (state)
                MS_IDLE: begin
                    if (req) begin
                        state  <= MS_WAIT;
                        sid_q  <= sid_in;
                        prio_q <= prio_in;
                        rem_q  <= beats_in;
                        age_q  <= '0;
                        susp_q <= 1'b0;
                    end
                end
                MS_WAIT: begin
                    if (start) begin
                        state  <= MS_ARB;
                        cnt_q  <= CNT_W'(ARB_LAT - 1);
                        susp_q <= 1'b0;
                    end else if (age_q != {AGE_W{1'b1}}) begin
                        age_q <= age_q + 1'b1;
                    end
                end
                MS_ARB: begin
                    if (cnt_q == '0) begin
                        state <= MS_LAT;
                        cnt_q <= CNT_W'(ACC_LAT - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                MS_LAT: begin
                    if (cnt_q == '0) state <= MS_XFER;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                MS_XFER: begin
                    rem_q <= rem_q - 1'b1;
                    if (rem_q <= BEAT_W'(1)) begin
                        state <= MS_IDLE;
                    end else if (preempt) begin
                        state  <= MS_WAIT;
                        susp_q <= 1'b1;
                        age_q  <= '0;
                    end
                end
                default: state <= MS_IDLE;
            endcase
        end
    end

    // outputs decoded from the state
    always_comb begin
        grant = (state == MS_LAT) || (state == MS_XFER);
        ready = (state == MS_XFER);
        susp  = (state == MS_WAIT) && susp_q;
    end
endmodule

// File: rtl/xbar_arb_pick.sv
module xbar_arb_pick #(
    parameter int N_MST  = 3,
    parameter int PRIO_W = 2,
    parameter int AGE_W  = 4,
    localparam int MID_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input  logic [N_MST-1:0]             cand,
    input  logic [N_MST-1:0][PRIO_W-1:0] prio,
    input  logic [N_MST-1:0][AGE_W-1:0]  age,
    output logic                         found,
    output logic [MID_W-1:0]             win,
    output logic [PRIO_W-1:0]            best_prio
);
    logic [AGE_W-1:0] best_age;

    // highest priority, then oldest, then lowest index
    always_comb begin
        found     = 1'b0;
        win       = '0;
        best_prio = '0;
        best_age  = '0;
        for (int m = 0; m < N_MST; m++) begin
            if (cand[m] && (!found || prio[m] > best_prio ||
                            (prio[m] == best_prio && age[m] > best_age))) begin
                found     = 1'b1;
                win       = MID_W'(m);
                best_prio = prio[m];
                best_age  = age[m];
            end
        end
    end
endmodule

// File: rtl/xbar_arb.sv
module xbar_arb
    import xbar_arb_pkg::*;
#(
    parameter int N_MST   = 3,
    parameter int N_SLV   = 2,
    parameter int MAX_ACT = 1,
    parameter int PRIO_W  = 2,
    parameter int BEAT_W  = 4,
    parameter int DATA_W  = 8,
    parameter int AGE_W   = 4,
    parameter int ARB_LAT = 2,
    parameter int ACC_LAT = 3,
    localparam int SID_W  = (N_SLV > 1) ? $clog2(N_SLV) : 1,
    localparam int MID_W  = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_MST-1:0]             m_req,
    input  logic [N_MST-1:0][SID_W-1:0]  m_sid,
    input  logic [N_MST-1:0][PRIO_W-1:0] m_prio,
    input  logic [N_MST-1:0][BEAT_W-1:0] m_beats,
    input  logic [N_MST-1:0][DATA_W-1:0] m_wdata,
    output logic [N_MST-1:0]             m_grant,
    output logic [N_MST-1:0]             m_ready,
    output logic [N_MST-1:0]             m_susp,
    output logic [N_SLV-1:0]             s_valid,
    output logic [N_SLV-1:0][DATA_W-1:0] s_data,
    output logic [N_SLV-1:0][MID_W-1:0]  s_mst
);
    mst_state_e                   st [N_MST];
    logic [N_MST-1:0][SID_W-1:0]  sid_q;
    logic [N_MST-1:0][PRIO_W-1:0] prio_q;
    logic [N_MST-1:0][AGE_W-1:0]  age_q;
    logic [N_MST-1:0]             start, preempt;

    logic [N_SLV-1:0]             found, busy;
    logic [N_SLV-1:0][MID_W-1:0]  win, hold;
    logic [N_SLV-1:0][PRIO_W-1:0] best_prio;

    for (genvar m = 0; m < N_MST; m++) begin : g_mst
        xbar_arb_mst #(
            .SID_W(SID_W), .PRIO_W(PRIO_W), .BEAT_W(BEAT_W), .AGE_W(AGE_W),
            .ARB_LAT(ARB_LAT), .ACC_LAT(ACC_LAT)
        ) u_mst (
            .clk(clk), .rst_n(rst_n),
            .req(m_req[m]), .sid_in(m_sid[m]), .prio_in(m_prio[m]),
            .beats_in(m_beats[m]), .start(start[m]), .preempt(preempt[m]),
            .state(st[m]), .sid_q(sid_q[m]), .prio_q(prio_q[m]), .age_q(age_q[m]),
            .grant(m_grant[m]), .ready(m_ready[m]), .susp(m_susp[m])
        );
    end

    for (genvar s = 0; s < N_SLV; s++) begin : g_slv
        logic [N_MST-1:0] cand;
        always_comb begin
            for (int m = 0; m < N_MST; m++)
                cand[m] = (st[m] == MS_WAIT) && (sid_q[m] == SID_W'(s));
        end
        xbar_arb_pick #(.N_MST(N_MST), .PRIO_W(PRIO_W), .AGE_W(AGE_W)) u_pick (
            .cand(cand), .prio(prio_q), .age(age_q),
            .found(found[s]), .win(win[s]), .best_prio(best_prio[s])
        );
    end

    // slave ownership, capacity budget, preemption and data routing
    always_comb begin
        int act_n;
        int room;
        busy    = '0;
        hold    = '0;
        start   = '0;
        preempt = '0;
        s_valid = '0;
        s_data  = '0;
        s_mst   = '0;
        act_n   = 0;
        for (int s = 0; s < N_SLV; s++) begin
            for (int m = 0; m < N_MST; m++) begin
                if ((st[m] == MS_ARB || st[m] == MS_LAT || st[m] == MS_XFER) &&
                    sid_q[m] == SID_W'(s)) begin
                    busy[s] = 1'b1;
                    hold[s] = MID_W'(m);
                end
            end
            if (busy[s]) act_n++;
        end
        room = MAX_ACT - act_n;
        for (int s = 0; s < N_SLV; s++) begin
            if (!busy[s] && found[s] && room > 0) begin
                start[win[s]] = 1'b1;
                room--;
            end
            if (busy[s] && st[hold[s]] == MS_XFER) begin
                s_valid[s] = 1'b1;
                s_data[s]  = m_wdata[hold[s]];
                s_mst[s]   = hold[s];
                if (found[s] && best_prio[s] > prio_q[hold[s]])
                    preempt[hold[s]] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xbar_arb_chk.sv
module xbar_arb_chk #(
    parameter int N_MST   = 3,
    parameter int N_SLV   = 2,
    parameter int MAX_ACT = 1,
    parameter int SID_W   = 1,
    parameter int MID_W   = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [N_MST-1:0]            m_grant,
    input logic [N_MST-1:0]            m_ready,
    input logic [N_MST-1:0]            m_susp,
    input logic [N_SLV-1:0]            s_valid,
    input logic [N_SLV-1:0][MID_W-1:0] s_mst,
    input logic [N_MST-1:0][SID_W-1:0] sid_q
);
    assert_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(m_grant) <= MAX_ACT)
        else $error("grant count above capacity");

    for (genvar s = 0; s < N_SLV; s++) begin : g_s
        logic [N_MST-1:0] own;
        always_comb begin
            for (int m = 0; m < N_MST; m++)
                own[m] = m_grant[m] && (sid_q[m] == SID_W'(s));
        end
        assert_one_owner_R11: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(own))
            else $error("two owners on one slave");
        assert_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
            s_valid[s] |-> m_ready[s_mst[s]])
            else $error("slave beat without master ready");
    end

    for (genvar m = 0; m < N_MST; m++) begin : g_m
        assert_susp_after_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(m_susp[m]) |-> $past(m_ready[m]))
            else $error("suspension without a completed beat");
        assert_susp_no_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
            m_susp[m] |-> !m_grant[m])
            else $error("suspended master still granted");
        assert_access_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(m_grant[m]) |-> !m_ready[m])
            else $error("beat on the grant cycle");
    end
endmodule

bind xbar_arb xbar_arb_chk #(
    .N_MST(N_MST), .N_SLV(N_SLV), .MAX_ACT(MAX_ACT), .SID_W(SID_W), .MID_W(MID_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .m_grant(m_grant), .m_ready(m_ready),
    .m_susp(m_susp), .s_valid(s_valid), .s_mst(s_mst), .sid_q(sid_q)
);

// File: tb/xbar_arb_bench.sv
`timescale 1ns/1ps
module xbar_arb_bench;
    logic clk = 1'b0;
    logic rst_n;
    always #2.5 clk = ~clk;

    logic [2:0]      req;
    logic [2:0][0:0] sid;
    logic [2:0][1:0] prio;
    logic [2:0][3:0] beats;
    logic [2:0][7:0] wdata;
    logic [2:0]      grant, ready, susp;
    logic [1:0]      s_valid;
    logic [1:0][7:0] s_data;
    logic [1:0][1:0] s_mst;

    xbar_arb u_xbar_arb (
        .clk(clk), .rst_n(rst_n), .m_req(req), .m_sid(sid), .m_prio(prio),
        .m_beats(beats), .m_wdata(wdata), .m_grant(grant), .m_ready(ready),
        .m_susp(susp), .s_valid(s_valid), .s_data(s_data), .s_mst(s_mst)
    );

    int beat_cnt [3];
    int route_err, s1_seen, susp_seen0, dual_grant;
    logic clr;
    int n_tests = 0;
    int n_fail  = 0;

    // master model: word = {index, beat number}, advances on ready
    always_comb begin
        for (int m = 0; m < 3; m++) wdata[m] = {4'(m), beat_cnt[m][3:0]};
    end

    always @(posedge clk) begin
        for (int m = 0; m < 3; m++)
            if (clr) beat_cnt[m] <= 0;
            else if (ready[m]) beat_cnt[m] <= beat_cnt[m] + 1;
    end

    always @(negedge clk) begin
        if (clr) begin
            route_err = 0; s1_seen = 0; susp_seen0 = 0; dual_grant = 0;
        end else if (rst_n) begin
            for (int s = 0; s < 2; s++)
                if (s_valid[s] && s_data[s] != {2'b00, s_mst[s], beat_cnt[s_mst[s]][3:0]})
                    route_err++;
            if (s_valid[1]) s1_seen = 1;
            if (susp[0]) susp_seen0 = 1;
            if ($countones(grant) > 1) dual_grant = 1;
        end
    end

    task automatic chk(string rq, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear();
        clr = 1'b1; step(); clr = 1'b0;
    endtask

    task automatic issue(int m, int s, int p, int b);
        req[m] = 1'b1; sid[m] = 1'(s); prio[m] = 2'(p); beats[m] = 4'(b);
        step();
        req[m] = 1'b0;
    endtask

    task automatic wait_bit(ref logic [2:0] v, input int m, output int cyc);
        cyc = 0;
        while (!v[m] && cyc < 300) begin step(); cyc++; end
    endtask

    task automatic wait_beats(int m, int n);
        for (int i = 0; i < 300 && beat_cnt[m] < n; i++) step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; clr = 1'b0; req = '0; sid = '0; prio = '0; beats = '0;
        repeat (3) step();
        chk("R1 grant", int'(grant), 0);
        chk("R1 ready/susp", int'({ready, susp}), 0);
        chk("R1 s_valid", int'(s_valid), 0);
        rst_n = 1'b1; step();
    endtask

    task automatic t_single();
        int c, n;
        clear();
        issue(0, 0, 1, 4);
        wait_bit(grant, 0, c);
        chk("R2 grant latency", c, 3);
        wait_bit(ready, 0, c);
        chk("R2 access delay", c, 3);
        n = 0;
        while (ready[0] && n < 50) begin n++; step(); end
        chk("R3 beat cycles", n, 4);
        chk("R3 beats taken", beat_cnt[0], 4);
        chk("R3 routing", route_err, 0);
    endtask

    task automatic t_prio();
        int i;
        clear();
        issue(0, 0, 3, 3);
        req[1] = 1'b1; sid[1] = 1'b0; prio[1] = 2'd1; beats[1] = 4'd2;
        req[2] = 1'b1; sid[2] = 1'b0; prio[2] = 2'd2; beats[2] = 4'd2;
        step(); req = '0;
        for (i = 0; i < 300 && !grant[1] && !grant[2]; i++) step();
        chk("R4 higher priority first", int'(grant[2:1]), 2);
        wait_beats(1, 2); wait_beats(2, 2);
        chk("R11 single owner", dual_grant, 0);
    endtask

    task automatic t_fifo();
        int i;
        clear();
        issue(0, 0, 3, 3);
        issue(2, 0, 1, 1);
        issue(1, 0, 1, 1);
        for (i = 0; i < 300 && !grant[1] && !grant[2]; i++) step();
        chk("R5 older first", int'(grant[2:1]), 2);
        wait_beats(1, 1); repeat (3) step();
    endtask

    task automatic t_cap();
        int viol = 0;
        int c;
        clear();
        issue(0, 0, 0, 5);
        issue(1, 1, 3, 2);
        for (int i = 0; i < 300 && beat_cnt[0] < 5; i++) begin
            if (grant[1]) viol++;
            step();
        end
        chk("R6 held back by cap", viol, 0);
        wait_bit(grant, 1, c);
        chk("R6 served after release", int'(grant[1]), 1);
        wait_beats(1, 2); repeat (3) step();
    endtask

    task automatic t_preempt();
        int c;
        clear();
        issue(0, 0, 0, 6);
        wait_bit(ready, 0, c);
        step();
        req[1] = 1'b1; sid[1] = 1'b0; prio[1] = 2'd2; beats[1] = 4'd2;
        step(); req[1] = 1'b0;
        chk("R7 beat in flight completes", int'({ready[0], susp[0]}), 2);
        step();
        chk("R7 suspended next cycle", int'({susp[0], ready[0], grant[0]}), 4);
        wait_beats(0, 6); repeat (4) step();
        chk("R9 preemptor beats", beat_cnt[1], 2);
        chk("R9 total beats, no repeat", beat_cnt[0], 6);
        chk("R9 resumed data order", route_err, 0);
        chk("R9 suspend cleared", int'(susp[0]), 0);
    endtask

    task automatic t_no_preempt();
        int c;
        clear();
        issue(0, 0, 1, 4);
        wait_bit(ready, 0, c);
        issue(1, 0, 1, 1);
        wait_beats(0, 4);
        chk("R8 equal priority keeps slave", susp_seen0, 0);
        wait_beats(1, 1); repeat (3) step();
    endtask

    task automatic t_ignore();
        clear();
        issue(0, 0, 1, 2);
        issue(0, 1, 1, 7);
        wait_beats(0, 2); repeat (15) step();
        chk("R10 beats unchanged", beat_cnt[0], 2);
        chk("R10 no second target", s1_seen, 0);
        chk("R10 idle afterwards", int'(grant[0]), 0);
    endtask

    task automatic t_reset_mid();
        int c;
        clear();
        issue(0, 0, 1, 8);
        wait_bit(ready, 0, c);
        rst_n = 1'b0; step();
        chk("R12 outputs cleared", int'({grant, ready, susp, s_valid}), 0);
        rst_n = 1'b1; step();
        repeat (10) step();
        chk("R12 queue flushed", int'(grant), 0);
        clear();
        issue(1, 0, 1, 2);
        wait_bit(grant, 1, c);
        chk("R12 fresh grant latency", c, 3);
        wait_beats(1, 2); repeat (3) step();
    endtask

    initial begin
        t_reset();
        t_single();
        t_prio();
        t_fifo();
        t_cap();
        t_preempt();
        t_no_preempt();
        t_ignore();
        t_reset_mid();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule